// File: doc/BRIEF.md
# Bidirectional message FIFO pair with end-of-transfer tagging

This block moves 32-bit message words between a host and an embedded controller through two eight-entry queues. The upstream queue carries words from the host towards the controller. The host pushes words on dedicated pins, and the controller pops them with a dequeue read. The downstream queue carries words from the controller towards the host. The controller pushes words with an enqueue write, and the host pops them on dedicated pins. Every stored word carries an end-of-transfer (EOT) tag, so a message boundary travels inside the queue with its data.

One 64-bit register port reaches both queues and decodes a 5-bit word offset. A dequeue read returns the popped word and a live status snapshot in the same access. Each queue clears in two steps: software first raises a reset request, and a later perform-reset write empties the queue. An EOT that has been signalled stays pending until a separate acknowledge write clears it.

Top module: `msg_fifo_pair`

## Requirements
- R1: Register offsets decode as follows. Upstream: dequeue 0x00, status 0x01, signal-EOT 0x02, request-reset 0x03, perform-reset 0x04, ack-EOT 0x05. Downstream: enqueue 0x10, status 0x11, signal-EOT 0x12, request-reset 0x13, perform-reset 0x14, ack-EOT 0x15. At most one queue action fires per access.
- R2: Each queue holds up to 8 entries. The 4-bit count field saturates at 8. The full flag is set exactly when the count is 8, and the empty flag exactly when the count is 0.
- R3: A dequeue read returns the head data in bits 63:32 and the upstream status word in bits 31:0, sampled before the pop, and removes one entry. On an empty queue it returns zero data with the valid bit clear and changes no state.
- R4: An enqueue write stores bits 63:32 of the write word. Bits 31:0 are ignored.
- R5: A push into a full queue is dropped and leaves the contents unchanged. It sets a sticky error bit that stays set until perform-reset.
- R6: Signal-EOT behaves as follows:
  - It sets the EOT tag of the newest entry.
  - On an empty queue it pushes a marker entry with zero data and the EOT tag set.
  - It sets the pending-EOT bit, which stays set until an ack-EOT write clears it.
- R7: A request-reset write sets only that queue's request flag and leaves its contents intact. A perform-reset write with any payload empties the queue and clears its request flag, its error bit and its pending-EOT bit.
- R8: A status word counts its bits from the MSB as bit 0, so bit b sits at word bit 31-b. The fields are:
  - bit 0: head valid (upstream only, 0 downstream)
  - bit 1: head EOT (upstream only)
  - bit 2: error
  - bit 6: request flag of the queue being reported
  - bit 7: request flag of the other queue
  - bit 8: pending EOT
  - bit 10: full
  - bit 11: empty
  - bits 12-15: count
- R9: Status bits 16+p hold the valid flag of queue position p, and bits 24+p hold its EOT flag. Position 0 is the head. Positions at or beyond the count read 0.
- R10: The host sees the downstream head on dn_valid_o, dn_eot_o and dn_data_o, with data 0 when empty. dn_pop_i removes the head. up_push_i stores up_data_i, and up_full_o reports the upstream full flag.
- R11: A status read returns the status word in bits 63:32 with bits 31:0 zero. Reads of write-only offsets return 0 and have no effect, and a write to the dequeue offset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Word offset |
| reg_wdata_i | input | 64 | Write word |
| reg_rdata_o | output | 64 | Read word, combinational in the access cycle |
| up_push_i | input | 1 | Host push into upstream queue |
| up_data_i | input | 32 | Host push data |
| up_full_o | output | 1 | Upstream queue full |
| dn_pop_i | input | 1 | Host pop from downstream queue |
| dn_valid_o | output | 1 | Downstream head present |
| dn_eot_o | output | 1 | Downstream head EOT tag |
| dn_data_o | output | 32 | Downstream head data |

## Verification
A slipped read or write pointer, or a wrong count, appears in the very next status read: the count field and the position-ordered valid mask disagree with the number of words pushed. It also appears in the next dequeued data word, so the bench reads status at every fill level from 0 to 9 and pops every entry. A misplaced EOT tag shows up in the per-position EOT flags and in the head-EOT bit one access later. A reset step that clears too much or too little shows up as a wrong count or a wrong swapped request bit, visible in the status of both queues.

// File: rtl/msg_fifo_pkg.sv
package msg_fifo_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 2 * WORD_W;
  localparam int FLAG_N = 8;

  localparam int OFF_UP_DEQ  = 'h00;
  localparam int OFF_UP_STAT = 'h01;
  localparam int OFF_UP_SIG  = 'h02;
  localparam int OFF_UP_REQ  = 'h03;
  localparam int OFF_UP_RST  = 'h04;
  localparam int OFF_UP_ACK  = 'h05;
  localparam int OFF_DN_ENQ  = 'h10;
  localparam int OFF_DN_STAT = 'h11;
  localparam int OFF_DN_SIG  = 'h12;
  localparam int OFF_DN_REQ  = 'h13;
  localparam int OFF_DN_RST  = 'h14;
  localparam int OFF_DN_ACK  = 'h15;

  // Status bits are numbered from the MSB: bit b lives at word bit 31-b.
  function automatic logic [WORD_W-1:0] pack_status(
    input logic             is_up,
    input logic             head_valid,
    input logic             head_eot,
    input logic             err,
    input logic             own_req,
    input logic             oth_req,
    input logic             pend,
    input logic             full,
    input logic             empty,
    input logic [3:0]       cnt,
    input logic [FLAG_N-1:0] vmask,
    input logic [FLAG_N-1:0] emask
  );
    logic [WORD_W-1:0] s;
    s = '0;
    s[31] = is_up & head_valid;
    s[30] = is_up & head_eot;
    s[29] = err;
    s[25] = own_req;
    s[24] = oth_req;
    s[23] = pend;
    s[21] = full;
    s[20] = empty;
    s[19:16] = cnt;
    for (int p = 0; p < FLAG_N; p++) begin
      s[15-p] = vmask[p];
      s[7-p]  = emask[p];
    end
    return s;
  endfunction
endpackage

// File: rtl/msg_fifo_chan.sv
module msg_fifo_chan #(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              sig_eot_i,
  input  logic              ack_eot_i,
  input  logic              req_rst_i,
  input  logic              do_rst_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_valid_o,
  output logic              head_eot_o,
  output logic [CW-1:0]     cnt_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [DEPTH-1:0]  pos_valid_o,
  output logic [DEPTH-1:0]  pos_eot_o,
  output logic              req_o,
  output logic              eot_pend_o,
  output logic              err_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  eot_q;
  logic [PW-1:0]     rd_q, wr_q, last_idx;
  logic [CW-1:0]     cnt_q;
  logic              req_q, pend_q, err_q;
  logic              eff_pop, eff_push, remain_nz, marker, tag_last, wr_en;

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign eff_pop   = pop_i & ~empty_o;
  assign eff_push  = push_i & ~full_o;
  assign remain_nz = (cnt_q - CW'(eff_pop)) != '0;
  // EOT goes onto a same-cycle push, else the newest entry, else a marker
  assign marker    = sig_eot_i & ~eff_push & ~remain_nz;
  assign tag_last  = sig_eot_i & ~eff_push & remain_nz;
  assign wr_en     = eff_push | marker;
  assign last_idx  = (wr_q == '0) ? PW'(DEPTH - 1) : wr_q - 1'b1;

  always_ff @(posedge clk_i) begin
    if (wr_en && !do_rst_i) mem_q[wr_q] <= eff_push ? push_data_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0; eot_q <= '0;
      req_q <= 1'b0; pend_q <= 1'b0; err_q <= 1'b0;
    end else if (do_rst_i) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0; eot_q <= '0;
      req_q <= 1'b0; pend_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (wr_en) begin
        eot_q[wr_q] <= sig_eot_i;
        wr_q        <= inc_ptr(wr_q);
      end
      if (tag_last) eot_q[last_idx] <= 1'b1;
      if (eff_pop) rd_q <= inc_ptr(rd_q);
      cnt_q <= cnt_q + CW'(wr_en) - CW'(eff_pop);
      if (req_rst_i) req_q <= 1'b1;
      if (sig_eot_i) pend_q <= 1'b1;
      else if (ack_eot_i) pend_q <= 1'b0;
      if (push_i && full_o) err_q <= 1'b1;
    end
  end

  assign head_valid_o = ~empty_o;
  assign head_data_o  = empty_o ? '0 : mem_q[rd_q];
  assign head_eot_o   = ~empty_o & eot_q[rd_q];
  assign cnt_o        = cnt_q;
  assign req_o        = req_q;
  assign eot_pend_o   = pend_q;
  assign err_o        = err_q;

  for (genvar p = 0; p < DEPTH; p++) begin : g_pos
    logic [PW:0]   pos_sum;
    logic [PW-1:0] pos_idx;
    assign pos_sum = {1'b0, rd_q} + (PW+1)'(p);
    assign pos_idx = (pos_sum >= (PW+1)'(DEPTH)) ? PW'(pos_sum - (PW+1)'(DEPTH))
                                                 : PW'(pos_sum);
    assign pos_valid_o[p] = (CW'(p) < cnt_q);
    assign pos_eot_o[p]   = (CW'(p) < cnt_q) & eot_q[pos_idx];
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_drop_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !sig_eot_i && !do_rst_i)
      |=> (cnt_q == $past(cnt_q) && err_o));
  p_empty_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !sig_eot_i && !do_rst_i) |=> empty_o);
  p_sig_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_eot_i && !do_rst_i) |=> (eot_pend_o && !empty_o));
  p_ack_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_eot_i && !sig_eot_i && !do_rst_i) |=> !eot_pend_o);
  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rst_i && !do_rst_i) |=> req_o);
  p_perform_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_rst_i |=> (empty_o && !req_o && !err_o && !eot_pend_o));
endmodule

// File: rtl/msg_fifo_regs.sv
module msg_fifo_regs
  import msg_fifo_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] up_head_i,
  input  logic [WORD_W-1:0] up_status_i,
  input  logic [WORD_W-1:0] dn_status_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              up_pop_o,
  output logic              up_sig_o,
  output logic              up_req_o,
  output logic              up_rst_o,
  output logic              up_ack_o,
  output logic              dn_push_o,
  output logic              dn_sig_o,
  output logic              dn_req_o,
  output logic              dn_rst_o,
  output logic              dn_ack_o
);
  logic rd, wr;
  assign rd = req_i & ~we_i;
  assign wr = req_i & we_i;

  assign up_pop_o  = rd & (addr_i == ADDR_W'(OFF_UP_DEQ));
  assign up_sig_o  = wr & (addr_i == ADDR_W'(OFF_UP_SIG));
  assign up_req_o  = wr & (addr_i == ADDR_W'(OFF_UP_REQ));
  assign up_rst_o  = wr & (addr_i == ADDR_W'(OFF_UP_RST));
  assign up_ack_o  = wr & (addr_i == ADDR_W'(OFF_UP_ACK));
  assign dn_push_o = wr & (addr_i == ADDR_W'(OFF_DN_ENQ));
  assign dn_sig_o  = wr & (addr_i == ADDR_W'(OFF_DN_SIG));
  assign dn_req_o  = wr & (addr_i == ADDR_W'(OFF_DN_REQ));
  assign dn_rst_o  = wr & (addr_i == ADDR_W'(OFF_DN_RST));
  assign dn_ack_o  = wr & (addr_i == ADDR_W'(OFF_DN_ACK));

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (addr_i == ADDR_W'(OFF_UP_DEQ))       rdata_o = {up_head_i, up_status_i};
      else if (addr_i == ADDR_W'(OFF_UP_STAT)) rdata_o = {up_status_i, {WORD_W{1'b0}}};
      else if (addr_i == ADDR_W'(OFF_DN_STAT)) rdata_o = {dn_status_i, {WORD_W{1'b0}}};
    end
  end

  always_comb begin
    p_one_action_r1: assert ($onehot0({up_pop_o, up_sig_o, up_req_o, up_rst_o, up_ack_o,
                                       dn_push_o, dn_sig_o, dn_req_o, dn_rst_o, dn_ack_o}));
  end
endmodule

// File: rtl/msg_fifo_pair.sv
module msg_fifo_pair
  import msg_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  input  logic              up_push_i,
  input  logic [31:0]       up_data_i,
  output logic              up_full_o,
  input  logic              dn_pop_i,
  output logic              dn_valid_o,
  output logic              dn_eot_o,
  output logic [31:0]       dn_data_o
);
  localparam int CW = $clog2(DEPTH + 1);

  if (DEPTH > FLAG_N || DEPTH < 1) begin : g_bad_depth
    $error("DEPTH must lie in 1..8 to fit the status flag fields");
  end

  logic up_pop, up_sig, up_req, up_rst, up_ack;
  logic dn_push, dn_sig, dn_req, dn_rst, dn_ack;

  logic [WORD_W-1:0] up_head, up_status, dn_status;
  logic              up_hv, up_he, up_empty, up_rq, up_pend, up_err;
  logic              dn_full, dn_empty, dn_rq, dn_pend, dn_err;
  logic [CW-1:0]     up_cnt, dn_cnt;
  logic [DEPTH-1:0]  up_pv, up_pe, dn_pv, dn_pe;
  logic              unused_wlo;

  assign unused_wlo = ^reg_wdata_i[WORD_W-1:0];

  msg_fifo_regs #(.ADDR_W(ADDR_W)) regs_i (
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .up_head_i(up_head), .up_status_i(up_status), .dn_status_i(dn_status),
    .rdata_o(reg_rdata_o),
    .up_pop_o(up_pop), .up_sig_o(up_sig), .up_req_o(up_req), .up_rst_o(up_rst),
    .up_ack_o(up_ack), .dn_push_o(dn_push), .dn_sig_o(dn_sig), .dn_req_o(dn_req),
    .dn_rst_o(dn_rst), .dn_ack_o(dn_ack)
  );

  msg_fifo_chan #(.DEPTH(DEPTH), .DATA_W(WORD_W)) up_i (
    .clk_i, .rst_ni,
    .push_i(up_push_i), .push_data_i(up_data_i), .pop_i(up_pop),
    .sig_eot_i(up_sig), .ack_eot_i(up_ack), .req_rst_i(up_req), .do_rst_i(up_rst),
    .head_data_o(up_head), .head_valid_o(up_hv), .head_eot_o(up_he),
    .cnt_o(up_cnt), .full_o(up_full_o), .empty_o(up_empty),
    .pos_valid_o(up_pv), .pos_eot_o(up_pe),
    .req_o(up_rq), .eot_pend_o(up_pend), .err_o(up_err)
  );

  msg_fifo_chan #(.DEPTH(DEPTH), .DATA_W(WORD_W)) dn_i (
    .clk_i, .rst_ni,
    .push_i(dn_push), .push_data_i(reg_wdata_i[REG_W-1:WORD_W]), .pop_i(dn_pop_i),
    .sig_eot_i(dn_sig), .ack_eot_i(dn_ack), .req_rst_i(dn_req), .do_rst_i(dn_rst),
    .head_data_o(dn_data_o), .head_valid_o(dn_valid_o), .head_eot_o(dn_eot_o),
    .cnt_o(dn_cnt), .full_o(dn_full), .empty_o(dn_empty),
    .pos_valid_o(dn_pv), .pos_eot_o(dn_pe),
    .req_o(dn_rq), .eot_pend_o(dn_pend), .err_o(dn_err)
  );

  // Own request sits in bit 6, the other queue's in bit 7
  assign up_status = pack_status(1'b1, up_hv, up_he, up_err, up_rq, dn_rq, up_pend,
                                 up_full_o, up_empty, 4'(up_cnt),
                                 FLAG_N'(up_pv), FLAG_N'(up_pe));
  assign dn_status = pack_status(1'b0, dn_valid_o, dn_eot_o, dn_err, dn_rq, up_rq, dn_pend,
                                 dn_full, dn_empty, 4'(dn_cnt),
                                 FLAG_N'(dn_pv), FLAG_N'(dn_pe));
endmodule

// File: tb/msg_fifo_pair_tb.sv
module msg_fifo_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_UDEQ = 5'h00, A_USTAT = 5'h01, A_USIG = 5'h02, A_UREQ = 5'h03,
                         A_URST = 5'h04, A_UACK = 5'h05, A_DENQ = 5'h10, A_DSTAT = 5'h11,
                         A_DSIG = 5'h12, A_DREQ = 5'h13, A_DRST = 5'h14, A_DACK = 5'h15;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        up_push = 1'b0, up_full, dn_pop = 1'b0, dn_valid, dn_eot;
  logic [31:0] up_data = '0, dn_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_fifo_pair dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .up_push_i(up_push), .up_data_i(up_data), .up_full_o(up_full),
    .dn_pop_i(dn_pop), .dn_valid_o(dn_valid), .dn_eot_o(dn_eot), .dn_data_o(dn_data)
  );

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  // Expected status from MSB-0 field positions
  function automatic logic [31:0] st(bit up, int k, logic [7:0] em, bit err,
                                     bit own, bit oth, bit pend);
    logic [31:0] s = '0;
    s[31-0]  = up && k > 0;
    s[31-1]  = up && k > 0 && em[0];
    s[31-2]  = err;
    s[31-6]  = own;
    s[31-7]  = oth;
    s[31-8]  = pend;
    s[31-10] = (k == 8);
    s[31-11] = (k == 0);
    s[19:16] = 4'(k);
    for (int p = 0; p < 8; p++) begin
      s[31-16-p] = (p < k);
      s[31-24-p] = (p < k) && em[p];
    end
    return s;
  endfunction

  function automatic logic [31:0] dpat(int n, int i);
    return {8'(n), 8'(i), 16'hC3A5};
  endfunction

  task automatic rd(logic [4:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_req = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic hpush(logic [31:0] d);
    @(negedge clk); up_push = 1'b1; up_data = d;
    @(posedge clk); #1 up_push = 1'b0;
  endtask

  task automatic hpop();
    @(negedge clk); dn_pop = 1'b1;
    @(posedge clk); #1 dn_pop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // Reset state (R8, R11)
    rd(A_USTAT, d); chk("R8 up reset status", d, {st(1, 0, 0, 0, 0, 0, 0), 32'h0});
    rd(A_DSTAT, d); chk("R11 dn reset status", d, {st(0, 0, 0, 0, 0, 0, 0), 32'h0});
    chk("R10 dn idle", {dn_valid, dn_eot, dn_data}, '0);

    // Upstream fill sweep, descending so the sticky error must clear (R2 R3 R5 R9 R7)
    for (int n = 9; n >= 0; n--) begin
      int k;
      wr(A_URST, 64'h1 << 32);
      for (int i = 0; i < n; i++) hpush(dpat(n, i));
      k = (n > 8) ? 8 : n;
      rd(A_USTAT, d); chk("R2 R5 R9 up status", d, {st(1, k, 0, n > 8, 0, 0, 0), 32'h0});
      chk("R10 up_full", 64'(up_full), 64'(k == 8));
      for (int j = 0; j <= k; j++) begin
        rd(A_UDEQ, d);
        if (j < k) chk("R3 dequeue", d, {dpat(n, j), st(1, k - j, 0, n > 8, 0, 0, 0)});
        else       chk("R3 empty dequeue", d, {32'h0, st(1, 0, 0, n > 8, 0, 0, 0)});
      end
      rd(A_USTAT, d); chk("R3 empty unchanged", d, {st(1, 0, 0, n > 8, 0, 0, 0), 32'h0});
    end

    // Downstream fill sweep via enqueue writes with junk low word (R4 R5 R10)
    for (int n = 9; n >= 0; n--) begin
      int k;
      wr(A_DRST, 64'h0);
      for (int i = 0; i < n; i++) wr(A_DENQ, {dpat(n, i), 32'hDEADBEEF});
      k = (n > 8) ? 8 : n;
      rd(A_DSTAT, d); chk("R4 R5 dn status", d, {st(0, k, 0, n > 8, 0, 0, 0), 32'h0});
      for (int j = 0; j < k; j++) begin
        @(negedge clk); #1;
        chk("R10 R4 dn head", {31'h0, dn_valid, dpat(0, 0)}, {31'h0, 1'b1, 32'hC3A5 | 32'h0});
        chk("R4 dn data", 64'(dn_data), 64'(dpat(n, j)));
        hpop();
      end
      rd(A_DSTAT, d); chk("R10 dn drained", d, {st(0, 0, 0, n > 8, 0, 0, 0), 32'h0});
    end

    // Upstream EOT tagging, marker and acknowledge (R6)
    wr(A_URST, 64'h1 << 32);
    for (int i = 0; i < 3; i++) hpush(dpat(3, i));
    wr(A_USIG, 64'h0);
    rd(A_USTAT, d); chk("R6 tag last", d, {st(1, 3, 8'b100, 0, 0, 0, 1), 32'h0});
    rd(A_UDEQ, d); chk("R6 deq0", d, {dpat(3, 0), st(1, 3, 8'b100, 0, 0, 0, 1)});
    rd(A_UDEQ, d); chk("R6 deq1", d, {dpat(3, 1), st(1, 2, 8'b010, 0, 0, 0, 1)});
    rd(A_UDEQ, d); chk("R6 deq2 eot head", d, {dpat(3, 2), st(1, 1, 8'b001, 0, 0, 0, 1)});
    rd(A_USTAT, d); chk("R6 pend held", d, {st(1, 0, 0, 0, 0, 0, 1), 32'h0});
    wr(A_UACK, 64'h1 << 32);
    rd(A_USTAT, d); chk("R6 ack clears", d, {st(1, 0, 0, 0, 0, 0, 0), 32'h0});
    wr(A_USIG, 64'h0);
    rd(A_UDEQ, d); chk("R6 marker", d, {32'h0, st(1, 1, 8'b001, 0, 0, 0, 1)});
    wr(A_UACK, 64'h0);

    // Downstream EOT (R6 R10)
    wr(A_DSIG, 64'h0);
    @(negedge clk); #1;
    chk("R6 dn marker head", {dn_valid, dn_eot, dn_data}, {1'b1, 1'b1, 32'h0});
    wr(A_DENQ, {32'h1111_0001, 32'h0});
    wr(A_DENQ, {32'h1111_0002, 32'h0});
    wr(A_DSIG, 64'h0);
    rd(A_DSTAT, d); chk("R6 dn tag last", d, {st(0, 3, 8'b101, 0, 0, 0, 1), 32'h0});
    wr(A_DACK, 64'h0);
    rd(A_DSTAT, d); chk("R6 dn ack keeps tags", d, {st(0, 3, 8'b101, 0, 0, 0, 0), 32'h0});
    wr(A_DRST, 64'h0);

    // Reset handshake with swapped request bits (R7 R8)
    hpush(32'hAAAA_0000); hpush(32'hAAAA_0001);
    wr(A_UREQ, 64'h0);
    rd(A_USTAT, d); chk("R7 req keeps data", d, {st(1, 2, 0, 0, 1, 0, 0), 32'h0});
    rd(A_DSTAT, d); chk("R8 dn sees other req", d, {st(0, 0, 0, 0, 0, 1, 0), 32'h0});
    wr(A_DREQ, 64'h0);
    rd(A_USTAT, d); chk("R8 both req up", d, {st(1, 2, 0, 0, 1, 1, 0), 32'h0});
    rd(A_DSTAT, d); chk("R8 both req dn", d, {st(0, 0, 0, 0, 1, 1, 0), 32'h0});
    wr(A_URST, 64'h0);
    rd(A_USTAT, d); chk("R7 perform up", d, {st(1, 0, 0, 0, 0, 1, 0), 32'h0});
    rd(A_DSTAT, d); chk("R7 dn req stays", d, {st(0, 0, 0, 0, 1, 0, 0), 32'h0});
    wr(A_DRST, 64'h0);
    rd(A_DSTAT, d); chk("R7 perform dn", d, {st(0, 0, 0, 0, 0, 0, 0), 32'h0});

    // Write-only offsets and dequeue-offset write (R11 R1)
    hpush(32'hBBBB_0000);
    rd(A_USIG, d);  chk("R11 read sig offset", d, 64'h0);
    rd(A_URST, d);  chk("R11 read rst offset", d, 64'h0);
    rd(A_DENQ, d);  chk("R11 read enq offset", d, 64'h0);
    wr(A_UDEQ, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_USTAT, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_USTAT, d); chk("R1 R11 no side effect", d, {st(1, 1, 0, 0, 0, 0, 0), 32'h0});
    rd(A_UDEQ, d);  chk("R1 deq after", d, {32'hBBBB_0000, st(1, 1, 0, 0, 0, 0, 0)});

    finish_run();
  end
endmodule